// File: doc/BRIEF.md
# Bitfield and Byte Manipulation Unit

This execution unit performs single-word bit-manipulation operations for a 32-bit integer datapath. Each request carries an operation code, a primary source word, an old destination word (used only by insert), a 5-bit position or rotate amount, a 5-bit size field and a variable rotate amount word. The unit computes one result per request and returns it after a single register stage. Alongside the result it returns a flag that marks a field combination the operation cannot honour.

The covered operations are:
- field extract and field insert;
- rotate right, with the amount taken either from the immediate position field or from a register word;
- sign extension from a byte or from a halfword;
- a swap of the two bytes inside each 16-bit half of the word.

A full byte reversal of a word is built from two passes: rotate right by 16, then the halfword byte swap.

Requests enter on a valid/ready handshake and results leave on another one. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. The input is ready whenever the output register is empty or is being drained in the same cycle. Back-pressure therefore reaches the input in the same cycle, and a stalled result holds still until it is taken.

Top module: `bitops_unit`

## Requirements
- R1: Extract (op code 0) returns `in_rs` shifted right by `in_pos` and masked to `in_size`+1 bits, with the upper bits zero.
- R2: Insert (op code 1) treats `in_size` as the field's top bit number. It places bits `in_size`-`in_pos`:0 of `in_rs` into `in_rt` at bit `in_pos`, and leaves every other bit of `in_rt` unchanged.
- R3: Rotate-immediate (op code 2) returns `in_rs` rotated right by `in_pos`; an amount of 0 returns the word unchanged.
- R4: Rotate-register (op code 3) rotates `in_rs` right by `in_amt[4:0]`; bits 31:5 of `in_amt` have no effect.
- R5: Byte sign-extend (op code 4) returns bit 7 of `in_rs` copied into bits 31:8, with bits 7:0 passed through.
- R6: Halfword sign-extend (op code 5) returns bit 15 of `in_rs` copied into bits 31:16, with bits 15:0 passed through.
- R7: Halfword byte swap (op code 6) exchanges bytes 0 and 1 and, separately, bytes 2 and 3.
- R8: The result is zero and `out_unpred` is high in three cases: an extract with `in_pos`+`in_size`+1 > 32, an insert with `in_size` < `in_pos`, and op code 7. Otherwise `out_unpred` is low.
- R9: A request accepted at an edge is presented on `out_valid`/`out_data` right after that edge. If no new request is accepted when a result is taken, `out_valid` drops.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_unpred` hold their values and `in_ready` is low.
- R11: After reset, `out_valid` is low and `in_ready` is high.
- R12: Rotating a word right by 16 and feeding the result to the halfword byte swap yields the word with its four bytes in reversed order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 3 | Operation code (0..6, 7 reserved) |
| in_rs | input | 32 | Primary source word |
| in_rt | input | 32 | Old destination word for insert |
| in_pos | input | 5 | Field position or immediate rotate amount |
| in_size | input | 5 | Extract size minus one, or insert top bit number |
| in_amt | input | 32 | Variable rotate amount word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Result word |
| out_unpred | output | 1 | Field combination could not be honoured |

## Verification
The hardest case to reach is a result that stalls while another request is already waiting at the input. A new request must not overwrite the held word, and the waiting request must be accepted in the very cycle the stall lifts. The bench reaches this by running its request stream at full rate while a monitor lowers `out_ready` in irregular multi-cycle bursts. A scoreboard queue then checks that every result arrives once and in order. The field-boundary cases are driven directly: an extract ending exactly at bit 31 and one ending at bit 32, and an insert whose top bit equals or falls below its position.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

  // Operation codes carried on in_op.
  typedef enum logic [2:0] {
    OP_EXTRACT  = 3'd0,
    OP_INSERT   = 3'd1,
    OP_ROTR_IMM = 3'd2,
    OP_ROTR_REG = 3'd3,
    OP_SEXT_B   = 3'd4,
    OP_SEXT_H   = 3'd5,
    OP_HSWAP    = 3'd6,
    OP_RSVD     = 3'd7
  } bitop_e;

  // Selector for the byte-oriented helper.
  typedef enum logic [1:0] {
    BYT_SEXT_B = 2'd0,
    BYT_SEXT_H = 2'd1,
    BYT_HSWAP  = 2'd2
  } byte_sel_e;

endpackage

// File: rtl/bitops_field.sv
// Field extract and insert with range check.
module bitops_field #(
  parameter int W  = 32,
  parameter int SH = $clog2(W)
) (
  input  logic          is_insert,
  input  logic [W-1:0]  rs,
  input  logic [W-1:0]  rt,
  input  logic [SH-1:0] pos,
  input  logic [SH-1:0] fld,
  output logic [W-1:0]  res,
  output logic          bad
);
  localparam logic [SH+1:0] LIMIT = (SH+2)'(W);
  localparam logic [SH:0]   ONE   = (SH+1)'(1);

  logic [SH:0]   width;
  logic [SH+1:0] end_bit;
  logic [W-1:0]  mask;
  logic [W-1:0]  mask_at;
  logic [W-1:0]  ext_val;
  logic [W-1:0]  ins_val;

  always_comb begin
    if (is_insert) begin
      width   = {1'b0, fld} - {1'b0, pos} + ONE;
      end_bit = '0;
      bad     = (fld < pos);
    end else begin
      width   = {1'b0, fld} + ONE;
      end_bit = {2'b00, pos} + {1'b0, width};
      bad     = (end_bit > LIMIT);
    end
    // A shift by the full width yields zero, so mask becomes all ones.
    mask    = ~({W{1'b1}} << width);
    mask_at = mask << pos;
    ext_val = (rs >> pos) & mask;
    ins_val = (rt & ~mask_at) | ((rs << pos) & mask_at);
    if (bad)            res = '0;
    else if (is_insert) res = ins_val;
    else                res = ext_val;
  end
endmodule

// File: rtl/bitops_rotate.sv
// Rotate right by a variable amount.
module bitops_rotate #(
  parameter int W  = 32,
  parameter int SH = $clog2(W)
) (
  input  logic [W-1:0]  x,
  input  logic [SH-1:0] n,
  output logic [W-1:0]  y
);
  logic [2*W-1:0] dbl;

  always_comb begin
    dbl = {x, x} >> n;
    y   = dbl[W-1:0];
  end
endmodule

// File: rtl/bitops_bytes.sv
// Sign extension and per-halfword byte swap.
module bitops_bytes
  import bitops_pkg::*;
#(
  parameter int W = 32
) (
  input  byte_sel_e    sel,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int HALVES = W / 16;

  logic [W-1:0] swapped;

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    assign swapped[16*g +: 8]     = x[16*g + 8 +: 8];
    assign swapped[16*g + 8 +: 8] = x[16*g +: 8];
  end

  always_comb begin
    unique case (sel)
      BYT_SEXT_B: y = {{(W-8){x[7]}}, x[7:0]};
      BYT_SEXT_H: y = {{(W-16){x[15]}}, x[15:0]};
      default:    y = swapped;
    endcase
  end
endmodule

// File: rtl/bitops_unit.sv
// Top: operation select, result mux and output register stage.
module bitops_unit
  import bitops_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [DATA_W-1:0] in_rt,
  input  logic [SH_W-1:0]   in_pos,
  input  logic [SH_W-1:0]   in_size,
  input  logic [DATA_W-1:0] in_amt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_unpred
);
  bitop_e            op;
  logic [DATA_W-1:0] fld_res;
  logic              fld_bad;
  logic [SH_W-1:0]   rot_n;
  logic [DATA_W-1:0] rot_res;
  byte_sel_e         byt_sel;
  logic [DATA_W-1:0] byt_res;
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_bad;
  logic              accept;

  assign op = bitop_e'(in_op);

  bitops_field #(.W(DATA_W), .SH(SH_W)) u_field (
    .is_insert (op == OP_INSERT),
    .rs        (in_rs),
    .rt        (in_rt),
    .pos       (in_pos),
    .fld       (in_size),
    .res       (fld_res),
    .bad       (fld_bad)
  );

  // Only the low bits of the amount word steer the variable rotate.
  assign rot_n = (op == OP_ROTR_REG) ? in_amt[SH_W-1:0] : in_pos;

  bitops_rotate #(.W(DATA_W), .SH(SH_W)) u_rot (
    .x (in_rs),
    .n (rot_n),
    .y (rot_res)
  );

  always_comb begin
    unique case (op)
      OP_SEXT_B: byt_sel = BYT_SEXT_B;
      OP_SEXT_H: byt_sel = BYT_SEXT_H;
      default:   byt_sel = BYT_HSWAP;
    endcase
  end

  bitops_bytes #(.W(DATA_W)) u_bytes (
    .sel (byt_sel),
    .x   (in_rs),
    .y   (byt_res)
  );

  always_comb begin
    nxt_data = '0;
    nxt_bad  = 1'b0;
    unique case (op)
      OP_EXTRACT, OP_INSERT: begin
        nxt_data = fld_res;
        nxt_bad  = fld_bad;
      end
      OP_ROTR_IMM, OP_ROTR_REG:       nxt_data = rot_res;
      OP_SEXT_B, OP_SEXT_H, OP_HSWAP: nxt_data = byt_res;
      default:                        nxt_bad  = 1'b1;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_unpred <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_data   <= nxt_data;
      out_unpred <= nxt_bad;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bitops_unit_chk.sv
// Protocol and result-shape properties, bound into the top.
module bitops_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_unpred
);
  assert_accept_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_unpred));

  assert_unpred_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unpred |-> out_data == '0);

  assert_rsvd_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 3'd7 |=> out_unpred);

  assert_sext_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 3'd4 |=>
      out_data[DATA_W-1:8] == {(DATA_W-8){out_data[7]}} && !out_unpred);

  assert_sext_h_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 3'd5 |=>
      out_data[DATA_W-1:16] == {(DATA_W-16){out_data[15]}} && !out_unpred);
endmodule

bind bitops_unit bitops_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_unpred (out_unpred)
);

// File: tb/tb_bitops_unit.sv
module tb_bitops_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_rs = '0;
  logic [31:0] in_rt = '0;
  logic [4:0]  in_pos = '0;
  logic [4:0]  in_size = '0;
  logic [31:0] in_amt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_unpred;

  int errors = 0;
  int checks = 0;
  bit bp_mode = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] exp_d[$];
  logic        exp_u[$];
  string       exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bitops_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rs(in_rs), .in_rt(in_rt), .in_pos(in_pos),
    .in_size(in_size), .in_amt(in_amt), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_unpred(out_unpred)
  );

  task automatic check(input bit ok, input string tag, input logic [32:0] got,
                       input logic [32:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, expv);
    end
  endtask

  // Reference model written bit by bit from the requirements: {unpred, data}.
  function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] rs,
      input logic [31:0] rt, input int pos, input int sz, input logic [31:0] amt);
    logic [31:0] r = '0;
    int n;
    case (op)
      3'd0: begin
        if (pos + sz + 1 > 32) return {1'b1, 32'h0};
        for (int i = 0; i <= sz; i++) r[i] = rs[pos + i];
      end
      3'd1: begin
        if (sz < pos) return {1'b1, 32'h0};
        r = rt;
        for (int i = pos; i <= sz; i++) r[i] = rs[i - pos];
      end
      3'd2, 3'd3: begin
        n = (op == 3'd2) ? pos : int'(amt[4:0]);
        for (int i = 0; i < 32; i++) r[i] = rs[(i + n) % 32];
      end
      3'd4: begin
        for (int i = 0; i < 32; i++) r[i] = (i < 8) ? rs[i] : rs[7];
      end
      3'd5: begin
        for (int i = 0; i < 32; i++) r[i] = (i < 16) ? rs[i] : rs[15];
      end
      3'd6: r = {rs[23:16], rs[31:24], rs[7:0], rs[15:8]};
      default: return {1'b1, 32'h0};
    endcase
    return {1'b0, r};
  endfunction

  task automatic push_exp(input logic [32:0] e, input string tag);
    exp_d.push_back(e[31:0]);
    exp_u.push_back(e[32]);
    exp_tag.push_back(tag);
  endtask

  // Driver: presents one request and waits for acceptance.
  task automatic send_raw(input logic [2:0] op, input logic [31:0] rs,
      input logic [31:0] rt, input int pos, input int sz, input logic [31:0] amt,
      input logic [32:0] e, input string tag);
    @(negedge clk);
    in_op = op; in_rs = rs; in_rt = rt;
    in_pos = pos[4:0]; in_size = sz[4:0]; in_amt = amt;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    push_exp(e, tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] rs,
      input logic [31:0] rt, input int pos, input int sz, input logic [31:0] amt,
      input string tag);
    send_raw(op, rs, rt, pos, sz, amt, model(op, rs, rt, pos, sz, amt), tag);
  endtask

  // Monitor: drives out_ready, compares results, checks stall stability.
  logic [31:0] prev_d;
  logic        prev_u;
  bit          prev_stall = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = bp_mode ? ((cyc % 7) > 3 || (cyc % 3) == 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && out_data == prev_d && out_unpred == prev_u,
                "R10 hold", {out_unpred, out_data}, {prev_u, prev_d});
        if (out_valid && !out_ready)
          check(!in_ready, "R10 ready", {32'h0, in_ready}, 33'h0);
        if (out_valid && out_ready) begin
          if (exp_d.size() == 0) begin
            check(1'b0, "R9 extra result", {out_unpred, out_data}, 33'h0);
          end else begin
            check(out_data == exp_d[0] && out_unpred == exp_u[0], exp_tag[0],
                  {out_unpred, out_data}, {exp_u[0], exp_d[0]});
            void'(exp_d.pop_front());
            void'(exp_u.pop_front());
            void'(exp_tag.pop_front());
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_d = out_data;
        prev_u = out_unpred;
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 33'h0, 33'h1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] w;
    logic [31:0] rot;
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && in_ready, "R11 reset", {31'h0, out_valid, in_ready}, 33'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: latency, observed directly.
    @(negedge clk);
    in_op = 3'd2; in_rs = 32'h8000_0001; in_pos = 5'd1; in_valid = 1'b1;
    push_exp(model(3'd2, 32'h8000_0001, 0, 1, 0, 0), "R3 rotr imm 1");
    #1 check(!out_valid, "R9 before edge", {32'h0, out_valid}, 33'h0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    check(out_valid, "R9 after edge", {32'h0, out_valid}, 33'h1);
    @(negedge clk);
    @(negedge clk);
    #2 check(!out_valid, "R9 drain", {32'h0, out_valid}, 33'h0);

    // R1 extract
    send(3'd0, 32'hDEAD_BEEF, 0, 4, 7, 0, "R1 extract byte");
    send(3'd0, 32'hDEAD_BEEF, 0, 0, 31, 0, "R1 extract full");
    send(3'd0, 32'h8000_0000, 0, 31, 0, 0, "R1 extract top bit");
    send(3'd0, 32'hFFF0_1234, 0, 20, 11, 0, "R1 extract ends at 31");
    // R8 unpredictable
    send(3'd0, 32'hFFFF_FFFF, 0, 20, 12, 0, "R8 extract past 32");
    send(3'd1, 32'h0000_00FF, 32'h1234_5678, 9, 8, 0, "R8 insert msb<pos");
    send(3'd7, 32'h1234_5678, 0, 0, 0, 0, "R8 reserved op");
    // R2 insert
    send(3'd1, 32'h0000_00AB, 32'hFFFF_0000, 8, 15, 0, "R2 insert byte");
    send(3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 13, 13, 0, "R2 insert single bit");
    send(3'd1, 32'hCAFE_F00D, 32'h1111_1111, 0, 31, 0, "R2 insert full");
    // R3 / R4 rotate
    send(3'd2, 32'h1234_5678, 0, 0, 0, 0, "R3 rotr imm 0");
    send(3'd2, 32'h1234_5678, 0, 31, 0, 0, "R3 rotr imm 31");
    send(3'd3, 32'h1234_5678, 0, 0, 0, 32'hFFFF_FFE3, "R4 rotr reg high bits ignored");
    send(3'd3, 32'h0000_0001, 0, 7, 0, 32'h0000_0020, "R4 rotr reg amount 32 is 0");
    // R5 / R6 / R7
    send(3'd4, 32'h1234_5680, 0, 0, 0, 0, "R5 sext byte neg");
    send(3'd4, 32'hFFFF_FF7F, 0, 0, 0, 0, "R5 sext byte pos");
    send(3'd5, 32'h0000_8001, 0, 0, 0, 0, "R6 sext half neg");
    send(3'd5, 32'hABCD_7FFF, 0, 0, 0, 0, "R6 sext half pos");
    send(3'd6, 32'h1122_3344, 0, 0, 0, 0, "R7 halfword swap");

    // R12 byte reversal over two passes
    w = 32'hA1B2_C3D4;
    rot = {w[15:0], w[31:16]};
    send(3'd2, w, 0, 16, 0, 0, "R12 first pass");
    send_raw(3'd6, rot, 0, 0, 0, 0, {1'b0, w[7:0], w[15:8], w[23:16], w[31:24]},
             "R12 byte reversal");

    // Back-pressure phase: stream while out_ready stalls in bursts.
    bp_mode = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [31:0] a = 32'h9E37_79B9 * (k + 1);
      send(3'(k % 8), a, ~a, (k * 5) % 32, (k * 11) % 32, a ^ 32'h5A5A_0000,
           "R10 stream under stall");
    end

    repeat (50) @(negedge clk);
    bp_mode = 1'b0;
    repeat (10) @(negedge clk);
    check(exp_d.size() == 0, "R9 all results delivered", 33'(exp_d.size()), 33'h0);
    done = 1'b1;
    finish_run();
  end
endmodule